// File: doc/BRIEF.md
# Remote Block-Transfer DMA Channel

This block is a slave DMA engine that moves a block of bytes between a local buffer memory and a bidirectional host data port. The host writes a 16-bit start address and a 16-bit byte count one byte at a time, selects a mode and pulses a start input. In write mode the channel takes bytes from the port and stores them in memory. In read mode it fetches bytes from memory and presents them on the port. In send-packet mode the start address and the length come from input ports fed by the receive side, and the channel then behaves as a read. Every byte on the port moves under a request/acknowledge handshake.

After each byte the address steps up by one and the count steps down by one. When the count reaches zero the channel returns to idle, raises a one-cycle interrupt pulse and sets a completion flag. The flag stays set until the next accepted start. A count of zero at start finishes at once, with no port transfer.

The controller has seven states. IDLE waits for a start. FETCH issues a memory read. WAITD captures the returned byte. OFFER drives the byte and holds the request until the acknowledge. ACCEPT holds the request in write mode until the acknowledge. WGAP drops the request for one cycle between written bytes. DONE issues the interrupt. The transitions are as follows:
- IDLE goes to DONE when the starting count is zero, to ACCEPT in write mode, and to FETCH otherwise.
- FETCH goes to WAITD, and WAITD goes to OFFER.
- OFFER goes to DONE on the acknowledge of the last byte, and to FETCH on any other acknowledge.
- ACCEPT goes to DONE on the acknowledge of the last byte, and to WGAP on any other acknowledge.
- WGAP goes to ACCEPT.
- DONE goes to IDLE.

Top module: `rdma_channel`

## Requirements
- R1: After reset the channel is idle: busy, host_req, mem_req, irq and done are all 0.
- R2: A write to the byte registers with reg_we=1 loads a pointer byte. reg_sel=0 loads the address low byte, 1 the address high byte, 2 the count low byte and 3 the count high byte. Register writes made while busy=1 are ignored.
- R3: In read mode (mode=2'b10) the channel reads memory at the current address. It then asserts host_req and drives the byte on io_data until host_ack is sampled high.
- R4: host_req is low in the cycle after the cycle in which host_ack was sampled high with host_req high.
- R5: In write mode (mode=2'b01) the channel asserts host_req when it can accept a byte. In the cycle where host_ack is high it writes io_data to memory at the current address. host_req is low for one cycle between written bytes.
- R6: In send-packet mode (mode=2'b11) the address and the count are taken from snd_addr and snd_count at start, and the transfer proceeds as in read mode. The host pointer registers are not used.
- R7: Each transferred byte increments the 16-bit address, with the carry running across the byte boundary, and decrements the count.
- R8: When the final byte is acknowledged, irq is high for exactly one cycle and busy falls. done is 1 from the following cycle until the next accepted start, and an accepted start clears it.
- R9: A start with a count of zero raises irq in the next cycle and never asserts host_req.
- R10: A start with mode=2'b00, or a start while busy=1, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Pointer byte write strobe |
| reg_sel | input | 2 | Pointer byte select |
| reg_wdata | input | 8 | Pointer byte value |
| go | input | 1 | Start pulse |
| mode | input | 2 | Transfer mode: 01 write, 10 read, 11 send packet |
| snd_addr | input | 16 | Start address for send-packet mode |
| snd_count | input | 16 | Byte count for send-packet mode |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after a read strobe |
| io_data | inout | 8 | Bidirectional host data port |
| host_req | output | 1 | Transfer request to the host |
| host_ack | input | 1 | Host acknowledge |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Completion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest condition to reach from the ports is a change to the pointer registers, or a second start, while a transfer is running. The bench does this between two handshakes of a read. It then checks that the remaining bytes still come from the original addresses. The read starts at 0x00FE, so the run also crosses the carry from the low address byte into the high byte. A start with a zero count, and a start with an idle mode, show the short DONE path and the ignored path.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    typedef enum logic [1:0] {
        MODE_NONE  = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_READ  = 2'b10,
        MODE_SEND  = 2'b11
    } rdma_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WAITD,
        S_OFFER,
        S_ACCEPT,
        S_WGAP,
        S_DONE
    } rdma_state_e;
endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt
);
    localparam int ADDR_BYTES = ADDR_W / DATA_W;
    localparam int CNT_BYTES  = CNT_W / DATA_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            cnt  <= '0;
        end else if (load_en) begin
            addr <= load_addr;
            cnt  <= load_cnt;
        end else if (step) begin
            addr <= addr + ADDR_W'(1);
            cnt  <= cnt - CNT_W'(1);
        end else if (wr_en) begin
            for (int i = 0; i < ADDR_BYTES; i++) begin
                if (wr_sel == SEL_W'(i))
                    addr[i*DATA_W +: DATA_W] <= wr_data;
            end
            for (int j = 0; j < CNT_BYTES; j++) begin
                if (wr_sel == SEL_W'(ADDR_BYTES + j))
                    cnt[j*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/rdma_fsm.sv
module rdma_fsm
    import rdma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  rdma_mode_e        mode,
    input  logic              start_zero,
    input  logic              last,
    input  logic              host_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              go_ok,
    output logic              host_req,
    output logic              drive_en,
    output logic [DATA_W-1:0] hold_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic              step,
    output logic              irq,
    output logic              done,
    output logic              busy
);
    rdma_state_e state, state_n;

    assign go_ok = (state == S_IDLE) && go && (mode != MODE_NONE);

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (go_ok) begin
                    if (start_zero)              state_n = S_DONE;
                    else if (mode == MODE_WRITE) state_n = S_ACCEPT;
                    else                         state_n = S_FETCH;
                end
            end
            S_FETCH:  state_n = S_WAITD;
            S_WAITD:  state_n = S_OFFER;
            S_OFFER:  if (host_ack) state_n = last ? S_DONE : S_FETCH;
            S_ACCEPT: if (host_ack) state_n = last ? S_DONE : S_WGAP;
            S_WGAP:   state_n = S_ACCEPT;
            S_DONE:   state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            hold_q <= '0;
            done   <= 1'b0;
        end else begin
            state <= state_n;
            if (state == S_WAITD) hold_q <= mem_rdata;
            if (go_ok)                done <= 1'b0;
            else if (state == S_DONE) done <= 1'b1;
        end
    end

    always_comb begin
        host_req = 1'b0;
        drive_en = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        step     = 1'b0;
        irq      = 1'b0;
        unique case (state)
            S_IDLE:   ;
            S_FETCH:  mem_req = 1'b1;
            S_WAITD:  ;
            S_OFFER: begin
                host_req = 1'b1;
                drive_en = 1'b1;
                step     = host_ack;
            end
            S_ACCEPT: begin
                host_req = 1'b1;
                mem_req  = host_ack;
                mem_we   = host_ack;
                step     = host_ack;
            end
            S_WGAP:   ;
            S_DONE:   irq = 1'b1;
            default:  ;
        endcase
    end

    assign busy = (state != S_IDLE);
endmodule

// File: rtl/rdma_channel.sv
module rdma_channel
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int SEL_W  = $clog2((ADDR_W + CNT_W) / DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              go,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic [CNT_W-1:0]  snd_count,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    inout  wire  [DATA_W-1:0] io_data,
    output logic              host_req,
    input  logic              host_ack,
    output logic              busy,
    output logic              done,
    output logic              irq
);
    rdma_mode_e        mode_e;
    logic              go_ok, step, drive_en, load_en, start_zero, last;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] hold_q;

    assign mode_e     = rdma_mode_e'(mode);
    assign load_en    = go_ok && (mode_e == MODE_SEND);
    assign start_zero = (mode_e == MODE_SEND) ? (snd_count == '0) : (cnt == '0);
    assign last       = (cnt == CNT_W'(1));

    rdma_ptr #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we && !busy),
        .wr_sel   (reg_sel),
        .wr_data  (reg_wdata),
        .load_en  (load_en),
        .load_addr(snd_addr),
        .load_cnt (snd_count),
        .step     (step),
        .addr     (addr),
        .cnt      (cnt)
    );

    rdma_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .mode      (mode_e),
        .start_zero(start_zero),
        .last      (last),
        .host_ack  (host_ack),
        .mem_rdata (mem_rdata),
        .go_ok     (go_ok),
        .host_req  (host_req),
        .drive_en  (drive_en),
        .hold_q    (hold_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .step      (step),
        .irq       (irq),
        .done      (done),
        .busy      (busy)
    );

    assign mem_addr  = addr;
    assign mem_wdata = io_data;
    assign io_data   = drive_en ? hold_q : {DATA_W{1'bz}};
endmodule

// File: rtl/rdma_channel_chk.sv
module rdma_channel_chk (
    input logic clk,
    input logic rst_n,
    input logic host_req,
    input logic host_ack,
    input logic mem_req,
    input logic mem_we,
    input logic irq,
    input logic done,
    input logic busy,
    input logic drive_en
);
    AST_REQ_FALLS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        host_req && host_ack |=> !host_req); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_DONE_FOLLOWS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> done && !busy); // R8
    AST_WRITE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> host_req && host_ack && !drive_en); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !host_req && !mem_req && !irq); // R1
    AST_DRIVE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> host_req && !mem_req); // R3
endmodule

bind rdma_channel rdma_channel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_req(host_req),
    .host_ack(host_ack),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .irq     (irq),
    .done    (done),
    .busy    (busy),
    .drive_en(drive_en)
);

// File: tb/tb_rdma_channel.sv
module tb_rdma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        go = 1'b0;
    logic [1:0]  mode = '0;
    logic [15:0] snd_addr = '0;
    logic [15:0] snd_count = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    wire  [7:0]  io_data;
    logic        host_req;
    logic        host_ack = 1'b0;
    logic        busy, done, irq;
    logic        tb_oe = 1'b0;
    logic [7:0]  tb_dat = '0;
    logic [7:0]  mem [0:4095];
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    assign io_data = tb_oe ? tb_dat : 8'bz;

    always #4 clk = ~clk;

    rdma_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .go(go), .mode(mode), .snd_addr(snd_addr),
        .snd_count(snd_count), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .io_data(io_data), .host_req(host_req), .host_ack(host_ack),
        .busy(busy), .done(done), .irq(irq)
    );

    function automatic logic [7:0] pat(input logic [11:0] a);
        return a[7:0] ^ 8'h5A ^ {a[11:8], 4'h3};
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        else if (mem_req)      mem_rdata <= mem[mem_addr[11:0]];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_ptrs(input logic [15:0] a, input logic [15:0] c);
        write_reg(2'd0, a[7:0]);
        write_reg(2'd1, a[15:8]);
        write_reg(2'd2, c[7:0]);
        write_reg(2'd3, c[15:8]);
    endtask

    task automatic start(input logic [1:0] m);
        @(negedge clk);
        go = 1'b1; mode = m;
        @(negedge clk);
        go = 1'b0; mode = 2'b00;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 40 && !host_req; i++) @(negedge clk);
    endtask

    task automatic host_read(input logic [7:0] exp, input bit last, input string req);
        wait_req();
        check(req, host_req, 1'b1);
        check(req, io_data, exp);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        check("R4", host_req, 1'b0);
        if (last) check("R8", irq, 1'b1);
    endtask

    task automatic host_write(input logic [7:0] v, input bit last);
        wait_req();
        check("R5", host_req, 1'b1);
        tb_dat = v; tb_oe = 1'b1; host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0; tb_oe = 1'b0;
        check("R5", host_req, 1'b0);
        if (last) check("R8", irq, 1'b1);
    endtask

    task automatic expect_finish();
        @(negedge clk);
        check("R8", done, 1'b1);
        check("R8", irq, 1'b0);
        check("R8", busy, 1'b0);
    endtask

    task automatic t_reset();
        check("R1", busy, 1'b0);
        check("R1", host_req, 1'b0);
        check("R1", mem_req, 1'b0);
        check("R1", irq, 1'b0);
        check("R1", done, 1'b0);
    endtask

    task automatic t_read_carry();
        set_ptrs(16'h00FE, 16'd4);
        start(2'b10);
        check("R8", done, 1'b0);
        check("R3", busy, 1'b1);
        host_read(pat(12'h0FE), 1'b0, "R3");
        write_reg(2'd1, 8'h07);
        start(2'b01);
        host_read(pat(12'h0FF), 1'b0, "R2");
        host_read(pat(12'h100), 1'b0, "R7");
        host_read(pat(12'h101), 1'b1, "R10");
        expect_finish();
    endtask

    task automatic t_write();
        set_ptrs(16'h0200, 16'd3);
        start(2'b01);
        host_write(8'hA1, 1'b0);
        host_write(8'hB2, 1'b0);
        host_write(8'hC3, 1'b1);
        expect_finish();
        check("R5", mem[12'h200], 8'hA1);
        check("R5", mem[12'h201], 8'hB2);
        check("R7", mem[12'h202], 8'hC3);
        check("R7", mem[12'h203], pat(12'h203));
        check("R7", mem[12'h1FF], pat(12'h1FF));
    endtask

    task automatic t_send();
        set_ptrs(16'h0020, 16'd5);
        snd_addr = 16'h0310; snd_count = 16'd2;
        start(2'b11);
        host_read(pat(12'h310), 1'b0, "R6");
        host_read(pat(12'h311), 1'b1, "R6");
        expect_finish();
    endtask

    task automatic t_zero();
        bit saw_req = 1'b0;
        set_ptrs(16'h0400, 16'd0);
        start(2'b10);
        check("R9", irq, 1'b1);
        check("R9", host_req, 1'b0);
        @(negedge clk);
        check("R9", done, 1'b1);
        check("R9", busy, 1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (host_req) saw_req = 1'b1;
        end
        check("R9", saw_req, 1'b0);
    endtask

    task automatic t_mode_none();
        bit saw = 1'b0;
        set_ptrs(16'h0500, 16'd2);
        start(2'b00);
        for (int i = 0; i < 6; i++) begin
            if (busy || irq || host_req) saw = 1'b1;
            @(negedge clk);
        end
        check("R10", saw, 1'b0);
        check("R10", done, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = pat(12'(i));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_carry();
        t_write();
        t_send();
        t_zero();
        t_mode_none();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule